// File: doc/BRIEF.md
# Reorder Buffer with Operand Wakeup

This block is an eight-slot circular reorder buffer that sits between an in-order decoder and a set of out-of-order execution units. The decoder writes one instruction per cycle into the slot at the allocate pointer. The slot index returned on `allocTag` becomes the instruction's tag. Each source operand arrives either as a finished value or as the tag of an older in-flight instruction that will produce it. When a functional unit returns a result, it is broadcast as a tag, data and cause triple. Every waiting operand that carries that tag captures the data, and the producing slot is marked complete.

In each cycle the buffer offers at most one instruction for execution. It picks the oldest slot, counted from the commit pointer, that is occupied, has not started, and has both operands present. Completed instructions leave strictly in program order from the commit pointer, one per cycle, and present their destination register and result to the architectural state. If the instruction at the commit pointer completed with a non-zero cause, it does not commit. The buffer raises a one-cycle flush with that cause and empties itself by moving the allocate pointer back onto the commit pointer.

Top module: `reorder_buf`

## Requirements
- R1: After reset the buffer is empty: `allocReady` is 1, `allocTag` is 0, and `dispValid`, `commitValid` and `flushValid` are 0.
- R2: Each accepted allocation receives the current `allocTag`, and `allocTag` then advances by one modulo 8. A tag is the slot index.
- R3: With 8 uncommitted entries `allocReady` is 0. An allocation offered while `allocReady` is 0 is dropped and leaves `allocTag` unchanged.
- R4: A slot is dispatched only if it is occupied, has not been dispatched since allocation, and has both operands present. `dispOp` shows its opcode, and no slot is dispatched twice.
- R5: At most one slot dispatches per cycle. Among eligible slots, the one nearest the commit pointer in allocation order is chosen and shown on `dispTag`.
- R6: A source given with its ready flag at 0 carries a producer tag in its low 3 bits. A broadcast (`resValid`) of that tag replaces it with `resData`. From the next cycle on, the dispatch outputs show that value on `dispSrc1`/`dispSrc2`.
- R7: A broadcast in the same cycle as an allocation also resolves the operands of the entry being allocated. That entry can therefore dispatch in the following cycle with the broadcast data.
- R8: Entries commit one per cycle in allocation order, and only after their result has been broadcast. `commitValid` comes with that entry's `commitDest` and broadcast data on `commitData`.
- R9: When the entry at the commit pointer has completed with a non-zero cause, `flushValid` is 1 for one cycle with that cause on `flushCause`. In that cycle there is no commit and no dispatch, and any allocation is dropped. Afterwards the buffer is empty and `allocTag` equals the faulting entry's tag.
- R10: A cause of 0 marks normal completion. Such an entry commits and raises no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| allocValid | input | 1 | Decoder offers an instruction |
| allocOp | input | 4 | Opcode of the offered instruction |
| allocDest | input | 5 | Destination register number |
| allocSrc1Ready | input | 1 | 1: allocSrc1 is a value; 0: its low 3 bits are a producer tag |
| allocSrc1 | input | 16 | First source value or tag |
| allocSrc2Ready | input | 1 | 1: allocSrc2 is a value; 0: its low 3 bits are a producer tag |
| allocSrc2 | input | 16 | Second source value or tag |
| allocReady | output | 1 | A free slot exists |
| allocTag | output | 3 | Tag the next accepted allocation receives |
| resValid | input | 1 | A result is being broadcast |
| resTag | input | 3 | Tag of the producing entry |
| resData | input | 16 | Result value |
| resCause | input | 3 | Exception cause, 0 for none |
| dispValid | output | 1 | An entry is issued this cycle |
| dispTag | output | 3 | Tag of the issued entry |
| dispOp | output | 4 | Opcode of the issued entry |
| dispSrc1 | output | 16 | First operand value |
| dispSrc2 | output | 16 | Second operand value |
| commitValid | output | 1 | Head entry retires this cycle |
| commitDest | output | 5 | Destination of the retiring entry |
| commitData | output | 16 | Result of the retiring entry |
| flushValid | output | 1 | Head entry faulted; buffer is cleared |
| flushCause | output | 3 | Cause of the faulting entry |

## Verification
The bound checker watches, on every cycle, the properties that follow from pointer movement alone. These are the tag advancing on each accepted allocation, the dropping of allocations while full, the exclusion of commit and dispatch during a flush, the empty state right after it, and the rule that no tag is issued twice in a row. What the properties cannot see is data flow. That covers which slot was the oldest ready one once the pointers wrap, whether a broadcast value reached each waiting operand (including one arriving in the same cycle as its consumer), and whether results leave in program order with the correct destination. Those are shown only by the bench's reference queue, which is compared against every output on every cycle under directed and random traffic.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int ROB_DEPTH = 8;
  localparam int TAG_W     = $clog2(ROB_DEPTH);
  localparam int PTR_W     = TAG_W + 1;
  localparam int DATA_W    = 16;
  localparam int OP_W      = 4;
  localparam int REG_W     = 5;
  localparam int CAUSE_W   = 3;

  typedef logic [TAG_W-1:0] tag_t;

  // strobes from control to the slot datapath
  typedef struct packed {
    logic alloc;
    tag_t tailIdx;
    logic disp;
    tag_t dispIdx;
    logic retire;
    logic flush;
    tag_t headIdx;
  } robStrobe_t;
endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 allocValid,
  input  logic [ROB_DEPTH-1:0] useVec,
  input  logic [ROB_DEPTH-1:0] execVec,
  input  logic [ROB_DEPTH-1:0] readyVec,
  input  logic [ROB_DEPTH-1:0] doneVec,
  input  logic [ROB_DEPTH-1:0] faultVec,
  output robStrobe_t           strobe,
  output logic                 allocReady,
  output tag_t                 allocTag,
  output logic                 dispValid,
  output tag_t                 dispTag,
  output logic                 commitValid,
  output logic                 flushValid
);
  localparam logic [PTR_W-1:0] PTR_ONE = PTR_W'(1);

  logic [PTR_W-1:0] headPtr, tailPtr;
  tag_t headIdx, tailIdx, pickIdx;
  logic isFull, headDone, headFault, pickFound, doAlloc;
  logic [ROB_DEPTH-1:0] candVec;

  assign headIdx   = headPtr[TAG_W-1:0];
  assign tailIdx   = tailPtr[TAG_W-1:0];
  assign isFull    = (headIdx == tailIdx) && (headPtr[TAG_W] != tailPtr[TAG_W]);
  assign headDone  = useVec[headIdx] && doneVec[headIdx];
  assign headFault = headDone && faultVec[headIdx];
  assign candVec   = useVec & ~execVec & readyVec;

  // oldest eligible slot, scanning forward from the commit pointer
  always_comb begin
    pickFound = 1'b0;
    pickIdx   = headIdx;
    for (int k = 0; k < ROB_DEPTH; k++) begin
      tag_t probe;
      probe = headIdx + tag_t'(k);
      if (!pickFound && candVec[probe]) begin
        pickFound = 1'b1;
        pickIdx   = probe;
      end
    end
  end

  assign doAlloc     = allocValid && !isFull && !headFault;
  assign allocReady  = !isFull;
  assign allocTag    = tailIdx;
  assign dispValid   = pickFound && !headFault;
  assign dispTag     = pickIdx;
  assign commitValid = headDone && !headFault;
  assign flushValid  = headFault;

  always_comb begin
    strobe.alloc   = doAlloc;
    strobe.tailIdx = tailIdx;
    strobe.disp    = dispValid;
    strobe.dispIdx = pickIdx;
    strobe.retire  = commitValid;
    strobe.flush   = headFault;
    strobe.headIdx = headIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else if (headFault) begin
      tailPtr <= headPtr;
    end else begin
      if (doAlloc)     tailPtr <= tailPtr + PTR_ONE;
      if (commitValid) headPtr <= headPtr + PTR_ONE;
    end
  end
endmodule

// File: rtl/rob_slots.sv
module rob_slots
  import rob_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  robStrobe_t           strobe,
  input  logic [OP_W-1:0]      allocOp,
  input  logic [REG_W-1:0]     allocDest,
  input  logic                 allocSrc1Ready,
  input  logic [DATA_W-1:0]    allocSrc1,
  input  logic                 allocSrc2Ready,
  input  logic [DATA_W-1:0]    allocSrc2,
  input  logic                 resValid,
  input  tag_t                 resTag,
  input  logic [DATA_W-1:0]    resData,
  input  logic [CAUSE_W-1:0]   resCause,
  output logic [ROB_DEPTH-1:0] useVec,
  output logic [ROB_DEPTH-1:0] execVec,
  output logic [ROB_DEPTH-1:0] readyVec,
  output logic [ROB_DEPTH-1:0] doneVec,
  output logic [ROB_DEPTH-1:0] faultVec,
  output logic [OP_W-1:0]      dispOp,
  output logic [DATA_W-1:0]    dispSrc1,
  output logic [DATA_W-1:0]    dispSrc2,
  output logic [REG_W-1:0]     commitDest,
  output logic [DATA_W-1:0]    commitData,
  output logic [CAUSE_W-1:0]   flushCause
);
  logic [OP_W-1:0]    opArr    [ROB_DEPTH];
  logic [REG_W-1:0]   destArr  [ROB_DEPTH];
  logic [DATA_W-1:0]  src1Arr  [ROB_DEPTH];
  logic [DATA_W-1:0]  src2Arr  [ROB_DEPTH];
  logic [DATA_W-1:0]  dataArr  [ROB_DEPTH];
  logic [CAUSE_W-1:0] causeArr [ROB_DEPTH];

  // a broadcast that resolves the operands being written this cycle
  logic allocHit1, allocHit2;
  assign allocHit1 = resValid && !allocSrc1Ready && (allocSrc1[TAG_W-1:0] == resTag);
  assign allocHit2 = resValid && !allocSrc2Ready && (allocSrc2[TAG_W-1:0] == resTag);

  for (genvar s = 0; s < ROB_DEPTH; s++) begin : gSlot
    localparam tag_t SLOT = tag_t'(s);
    logic useQ, execQ, doneQ, p1Q, p2Q;
    logic [OP_W-1:0]    opQ;
    logic [REG_W-1:0]   destQ;
    logic [DATA_W-1:0]  s1Q, s2Q, dataQ;
    logic [CAUSE_W-1:0] causeQ;
    logic hit1, hit2, ownResult, allocHere;

    assign hit1      = resValid && !p1Q && (s1Q[TAG_W-1:0] == resTag);
    assign hit2      = resValid && !p2Q && (s2Q[TAG_W-1:0] == resTag);
    assign ownResult = resValid && useQ && (resTag == SLOT);
    assign allocHere = strobe.alloc && (strobe.tailIdx == SLOT);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        useQ <= 1'b0; execQ <= 1'b0; doneQ <= 1'b0;
        p1Q <= 1'b0; p2Q <= 1'b0;
        opQ <= '0; destQ <= '0; s1Q <= '0; s2Q <= '0;
        dataQ <= '0; causeQ <= '0;
      end else if (strobe.flush) begin
        useQ <= 1'b0;
      end else begin
        if (hit1) begin p1Q <= 1'b1; s1Q <= resData; end
        if (hit2) begin p2Q <= 1'b1; s2Q <= resData; end
        if (ownResult) begin
          doneQ  <= 1'b1;
          dataQ  <= resData;
          causeQ <= resCause;
        end
        if (strobe.disp && strobe.dispIdx == SLOT) execQ <= 1'b1;
        if (strobe.retire && strobe.headIdx == SLOT) useQ <= 1'b0;
        if (allocHere) begin
          useQ   <= 1'b1;
          execQ  <= 1'b0;
          doneQ  <= 1'b0;
          causeQ <= '0;
          opQ    <= allocOp;
          destQ  <= allocDest;
          p1Q    <= allocSrc1Ready || allocHit1;
          p2Q    <= allocSrc2Ready || allocHit2;
          s1Q    <= allocHit1 ? resData : allocSrc1;
          s2Q    <= allocHit2 ? resData : allocSrc2;
        end
      end
    end

    assign useVec[s]   = useQ;
    assign execVec[s]  = execQ;
    assign readyVec[s] = p1Q && p2Q;
    assign doneVec[s]  = doneQ;
    assign faultVec[s] = doneQ && (causeQ != '0);
    assign opArr[s]    = opQ;
    assign destArr[s]  = destQ;
    assign src1Arr[s]  = s1Q;
    assign src2Arr[s]  = s2Q;
    assign dataArr[s]  = dataQ;
    assign causeArr[s] = causeQ;
  end

  assign dispOp     = opArr[strobe.dispIdx];
  assign dispSrc1   = src1Arr[strobe.dispIdx];
  assign dispSrc2   = src2Arr[strobe.dispIdx];
  assign commitDest = destArr[strobe.headIdx];
  assign commitData = dataArr[strobe.headIdx];
  assign flushCause = causeArr[strobe.headIdx];
endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               allocValid,
  input  logic [OP_W-1:0]    allocOp,
  input  logic [REG_W-1:0]   allocDest,
  input  logic               allocSrc1Ready,
  input  logic [DATA_W-1:0]  allocSrc1,
  input  logic               allocSrc2Ready,
  input  logic [DATA_W-1:0]  allocSrc2,
  output logic               allocReady,
  output logic [TAG_W-1:0]   allocTag,
  input  logic               resValid,
  input  logic [TAG_W-1:0]   resTag,
  input  logic [DATA_W-1:0]  resData,
  input  logic [CAUSE_W-1:0] resCause,
  output logic               dispValid,
  output logic [TAG_W-1:0]   dispTag,
  output logic [OP_W-1:0]    dispOp,
  output logic [DATA_W-1:0]  dispSrc1,
  output logic [DATA_W-1:0]  dispSrc2,
  output logic               commitValid,
  output logic [REG_W-1:0]   commitDest,
  output logic [DATA_W-1:0]  commitData,
  output logic               flushValid,
  output logic [CAUSE_W-1:0] flushCause
);
  robStrobe_t strobe;
  logic [ROB_DEPTH-1:0] useVec, execVec, readyVec, doneVec, faultVec;

  rob_ctrl ctrl (
    .clk(clk), .rstN(rstN), .allocValid(allocValid),
    .useVec(useVec), .execVec(execVec), .readyVec(readyVec),
    .doneVec(doneVec), .faultVec(faultVec),
    .strobe(strobe), .allocReady(allocReady), .allocTag(allocTag),
    .dispValid(dispValid), .dispTag(dispTag),
    .commitValid(commitValid), .flushValid(flushValid)
  );

  rob_slots slots (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .allocOp(allocOp), .allocDest(allocDest),
    .allocSrc1Ready(allocSrc1Ready), .allocSrc1(allocSrc1),
    .allocSrc2Ready(allocSrc2Ready), .allocSrc2(allocSrc2),
    .resValid(resValid), .resTag(resTag), .resData(resData), .resCause(resCause),
    .useVec(useVec), .execVec(execVec), .readyVec(readyVec),
    .doneVec(doneVec), .faultVec(faultVec),
    .dispOp(dispOp), .dispSrc1(dispSrc1), .dispSrc2(dispSrc2),
    .commitDest(commitDest), .commitData(commitData), .flushCause(flushCause)
  );
endmodule

// File: rtl/reorder_buf_chk.sv
module reorder_buf_chk
  import rob_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             allocValid,
  input logic             allocReady,
  input logic [TAG_W-1:0] allocTag,
  input logic             dispValid,
  input logic [TAG_W-1:0] dispTag,
  input logic             commitValid,
  input logic             flushValid
);
  // R2
  tag_advance_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && allocReady && !flushValid) |=> (allocTag == $past(allocTag) + tag_t'(1)));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (allocValid && !allocReady && !flushValid) |=> $stable(allocTag));

  // R4
  single_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |=> !(dispValid && dispTag == $past(dispTag)));

  // R9
  flush_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> (!commitValid && !dispValid));

  // R9
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> (allocReady && !commitValid && !flushValid && !dispValid));
endmodule

bind reorder_buf reorder_buf_chk rob_chk_i (
  .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocReady(allocReady),
  .allocTag(allocTag), .dispValid(dispValid), .dispTag(dispTag),
  .commitValid(commitValid), .flushValid(flushValid)
);

// File: tb/reorder_buf_test.sv
module reorder_buf_test;
  import rob_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic allocValid = 1'b0, allocSrc1Ready = 1'b0, allocSrc2Ready = 1'b0;
  logic [OP_W-1:0] allocOp = '0;
  logic [REG_W-1:0] allocDest = '0;
  logic [DATA_W-1:0] allocSrc1 = '0, allocSrc2 = '0;
  logic resValid = 1'b0;
  logic [TAG_W-1:0] resTag = '0;
  logic [DATA_W-1:0] resData = '0;
  logic [CAUSE_W-1:0] resCause = '0;
  logic allocReady, dispValid, commitValid, flushValid;
  logic [TAG_W-1:0] allocTag, dispTag;
  logic [OP_W-1:0] dispOp;
  logic [DATA_W-1:0] dispSrc1, dispSrc2, commitData;
  logic [REG_W-1:0] commitDest;
  logic [CAUSE_W-1:0] flushCause;

  always #(CLK_PERIOD/2) clk = ~clk;

  reorder_buf uut (
    .clk(clk), .rstN(rstN), .allocValid(allocValid), .allocOp(allocOp),
    .allocDest(allocDest), .allocSrc1Ready(allocSrc1Ready), .allocSrc1(allocSrc1),
    .allocSrc2Ready(allocSrc2Ready), .allocSrc2(allocSrc2),
    .allocReady(allocReady), .allocTag(allocTag),
    .resValid(resValid), .resTag(resTag), .resData(resData), .resCause(resCause),
    .dispValid(dispValid), .dispTag(dispTag), .dispOp(dispOp),
    .dispSrc1(dispSrc1), .dispSrc2(dispSrc2),
    .commitValid(commitValid), .commitDest(commitDest), .commitData(commitData),
    .flushValid(flushValid), .flushCause(flushCause)
  );

  int checks = 0;
  int errors = 0;

  // program-order reference queue
  typedef struct packed {
    logic [TAG_W-1:0]   tag;
    logic [OP_W-1:0]    op;
    logic [REG_W-1:0]   dest;
    logic               p1;
    logic [DATA_W-1:0]  v1;
    logic               p2;
    logic [DATA_W-1:0]  v2;
    logic               ex;
    logic               done;
    logic [DATA_W-1:0]  data;
    logic [CAUSE_W-1:0] cause;
  } ent_t;
  ent_t q[$];
  int nextTag = 0;
  bit expFlush, expCommit, expDisp;
  int expIdx;

  function automatic void chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endfunction

  function automatic void calcExp();
    expFlush = 0; expCommit = 0; expDisp = 0; expIdx = 0;
    if (q.size() > 0 && q[0].done) begin
      if (q[0].cause != '0) expFlush = 1; else expCommit = 1;
    end
    if (!expFlush)
      for (int i = 0; i < q.size(); i++)
        if (!expDisp && !q[i].ex && q[i].p1 && q[i].p2) begin
          expDisp = 1;
          expIdx = i;
        end
  endfunction

  function automatic void compareAll();
    calcExp();
    chk(allocReady == (q.size() < ROB_DEPTH), "R3", "allocReady", int'(allocReady), int'(q.size() < ROB_DEPTH));
    chk(allocTag == TAG_W'(nextTag), "R2", "allocTag", int'(allocTag), nextTag);
    chk(flushValid == expFlush, "R9", "flushValid", int'(flushValid), int'(expFlush));
    if (expFlush && flushValid)
      chk(flushCause == q[0].cause, "R9", "flushCause", int'(flushCause), int'(q[0].cause));
    chk(commitValid == expCommit, "R8", "commitValid", int'(commitValid), int'(expCommit));
    if (expCommit && commitValid) begin
      chk(commitDest == q[0].dest, "R8", "commitDest", int'(commitDest), int'(q[0].dest));
      chk(commitData == q[0].data, "R8", "commitData", int'(commitData), int'(q[0].data));
    end
    chk(dispValid == expDisp, "R5", "dispValid", int'(dispValid), int'(expDisp));
    if (expDisp && dispValid) begin
      chk(dispTag == q[expIdx].tag, "R5", "dispTag", int'(dispTag), int'(q[expIdx].tag));
      chk(dispOp == q[expIdx].op, "R4", "dispOp", int'(dispOp), int'(q[expIdx].op));
      chk(dispSrc1 == q[expIdx].v1, "R6", "dispSrc1", int'(dispSrc1), int'(q[expIdx].v1));
      chk(dispSrc2 == q[expIdx].v2, "R6", "dispSrc2", int'(dispSrc2), int'(q[expIdx].v2));
    end
  endfunction

  function automatic void modelUpdate(bit aV, int op, int dest, bit r1, int s1, bit r2, int s2,
                                      bit rV, int rT, int rD, int rC);
    ent_t e;
    bit accept;
    calcExp();
    if (expFlush) begin
      nextTag = int'(q[0].tag);
      q.delete();
      return;
    end
    accept = aV && (q.size() < ROB_DEPTH);
    if (expDisp) begin e = q[expIdx]; e.ex = 1'b1; q[expIdx] = e; end
    if (rV)
      for (int i = 0; i < q.size(); i++) begin
        e = q[i];
        if (!e.p1 && e.v1[TAG_W-1:0] == TAG_W'(rT)) begin e.p1 = 1'b1; e.v1 = DATA_W'(rD); end
        if (!e.p2 && e.v2[TAG_W-1:0] == TAG_W'(rT)) begin e.p2 = 1'b1; e.v2 = DATA_W'(rD); end
        if (e.tag == TAG_W'(rT)) begin e.done = 1'b1; e.data = DATA_W'(rD); e.cause = CAUSE_W'(rC); end
        q[i] = e;
      end
    if (expCommit) void'(q.pop_front());
    if (accept) begin
      e = '0;
      e.tag  = TAG_W'(nextTag);
      e.op   = OP_W'(op);
      e.dest = REG_W'(dest);
      e.p1   = r1 || (rV && TAG_W'(s1) == TAG_W'(rT));
      e.v1   = (!r1 && rV && TAG_W'(s1) == TAG_W'(rT)) ? DATA_W'(rD) : DATA_W'(s1);
      e.p2   = r2 || (rV && TAG_W'(s2) == TAG_W'(rT));
      e.v2   = (!r2 && rV && TAG_W'(s2) == TAG_W'(rT)) ? DATA_W'(rD) : DATA_W'(s2);
      q.push_back(e);
      nextTag = (nextTag + 1) % ROB_DEPTH;
    end
  endfunction

  task automatic step(bit aV, int op, int dest, bit r1, int s1, bit r2, int s2,
                      bit rV, int rT, int rD, int rC);
    @(negedge clk);
    compareAll();
    allocValid = aV; allocOp = OP_W'(op); allocDest = REG_W'(dest);
    allocSrc1Ready = r1; allocSrc1 = DATA_W'(s1);
    allocSrc2Ready = r2; allocSrc2 = DATA_W'(s2);
    resValid = rV; resTag = TAG_W'(rT); resData = DATA_W'(rD); resCause = CAUSE_W'(rC);
    modelUpdate(aV, op, dest, r1, s1, r2, s2, rV, rT, rD, rC);
    @(posedge clk);
    #1;
    allocValid = 1'b0;
    resValid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic randCycle(bit allowAlloc);
    int pend[$];
    int execs[$];
    bit aV, r1, r2, rV;
    int s1, s2, rT, rC;
    foreach (q[i]) begin
      if (!q[i].done) pend.push_back(int'(q[i].tag));
      if (q[i].ex && !q[i].done) execs.push_back(int'(q[i].tag));
    end
    aV = allowAlloc && ($urandom_range(0, 3) != 0);
    r1 = (pend.size() == 0) || ($urandom_range(0, 1) == 1);
    s1 = r1 ? int'($urandom_range(0, 65535)) : pend[$urandom_range(0, pend.size() - 1)];
    r2 = (pend.size() == 0) || ($urandom_range(0, 1) == 1);
    s2 = r2 ? int'($urandom_range(0, 65535)) : pend[$urandom_range(0, pend.size() - 1)];
    rV = (execs.size() > 0) && ($urandom_range(0, 2) != 0);
    rT = rV ? execs[$urandom_range(0, execs.size() - 1)] : 0;
    rC = ($urandom_range(0, 24) == 0) ? int'($urandom_range(1, 7)) : 0;
    step(aV, int'($urandom_range(0, 15)), int'($urandom_range(0, 31)), r1, s1, r2, s2,
         rV, rT, int'($urandom_range(0, 65535)), rC);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(allocReady == 1'b1, "R1", "allocReady", int'(allocReady), 1);
    chk(allocTag == '0, "R1", "allocTag", int'(allocTag), 0);
    chk(!dispValid && !commitValid && !flushValid, "R1", "idle outputs",
        int'({dispValid, commitValid, flushValid}), 0);

    // tags 0,1,2: slot 1 waits on slot 0
    step(1, 1, 1, 1, 10, 1, 20, 0, 0, 0, 0);
    step(1, 2, 2, 0, 0, 1, 30, 0, 0, 0, 0);
    step(1, 3, 3, 1, 40, 1, 50, 0, 0, 0, 0);
    // R4: slot 1 is older but its operand is missing, so slot 2 goes
    chk(dispValid && dispTag == 3'd2, "R4", "dispTag with waiting older slot", int'(dispTag), 2);
    step(0, 0, 0, 1, 0, 1, 0, 1, 0, 55, 0);
    // R6: woken operand value appears on dispatch
    chk(dispValid && dispTag == 3'd1 && dispSrc1 == 16'd55, "R6", "dispSrc1 after wakeup",
        int'(dispSrc1), 55);
    step(0, 0, 0, 1, 0, 1, 0, 1, 2, 222, 0);
    step(0, 0, 0, 1, 0, 1, 0, 1, 1, 111, 0);
    idle(3);

    // tag 3 producer, tag 4 consumer allocated during the producer's broadcast
    step(1, 4, 4, 1, 5, 1, 6, 0, 0, 0, 0);
    idle(1);
    step(1, 5, 5, 0, 3, 1, 9, 1, 3, 16'h77, 0);
    // R7
    chk(dispValid && dispTag == 3'd4 && dispSrc1 == 16'h77, "R7", "same-cycle wakeup",
        int'(dispSrc1), 16'h77);
    // R10
    chk(commitValid && !flushValid && commitData == 16'h77 && commitDest == 5'd4, "R10",
        "normal completion commits", int'(commitData), 16'h77);
    step(0, 0, 0, 1, 0, 1, 0, 1, 4, 16'h88, 0);
    idle(3);

    // fault: tags 5 and 6, younger finishes first, older faults
    step(1, 6, 6, 1, 1, 1, 2, 0, 0, 0, 0);
    step(1, 7, 7, 1, 3, 1, 4, 0, 0, 0, 0);
    idle(1);
    step(0, 0, 0, 1, 0, 1, 0, 1, 6, 1, 0);
    step(0, 0, 0, 1, 0, 1, 0, 1, 5, 9, 5);
    // R9
    chk(flushValid && flushCause == 3'd5 && !commitValid && !dispValid, "R9", "flush pulse",
        int'(flushCause), 5);
    step(1, 8, 8, 1, 7, 1, 7, 0, 0, 0, 0);
    chk(allocTag == 3'd5 && allocReady && !dispValid && !commitValid, "R9",
        "empty after flush, allocation dropped", int'(allocTag), 5);

    // fill: tag 5 ready, tags 6,7,0..4 wait on tag 5
    step(1, 9, 9, 1, 1, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 7; i++) step(1, i, 10 + i, 0, 5, 1, 100 + i, 0, 0, 0, 0);
    chk(!allocReady, "R3", "allocReady when full", int'(allocReady), 0);
    step(1, 15, 31, 1, 1, 1, 1, 0, 0, 0, 0);
    chk(!allocReady && allocTag == 3'd5, "R3", "allocation dropped when full", int'(allocTag), 5);
    step(0, 0, 0, 1, 0, 1, 0, 1, 5, 16'h100, 0);
    // R5 oldest of seven newly ready slots
    chk(dispValid && dispTag == 3'd6, "R5", "oldest ready chosen", int'(dispTag), 6);
    idle(8);
    for (int i = 0; i < 7; i++) step(0, 0, 0, 1, 0, 1, 0, 1, (4 - i + ROB_DEPTH) % ROB_DEPTH, 16'h200 + i, 0);
    idle(4);

    // mixed traffic, then drain
    for (int i = 0; i < 4000; i++) randCycle(1'b1);
    for (int i = 0; i < 300; i++) randCycle(1'b0);
    @(negedge clk);
    compareAll();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule